// File: doc/BRIEF.md
# Video Stream Frame Position Tracker

This block sits in line on a video stream that carries one pixel per beat. Data, valid, end-of-line and the sideband bits pass straight through without change. The ready signal also passes straight through, from the downstream side back to the upstream side. Next to each beat, the block gives the column and line of that pixel within the frame. Bit 0 of the user sideband marks the start of a frame. The last flag closes each scanline.

Software programs the expected active width and height on two configuration inputs. The block checks every line and every frame against that geometry. It flags three cases on the beat where they occur:
- a line that ends too soon,
- a line that runs past its expected length,
- a frame that restarts before all its lines have arrived.

Until the first start-of-frame after reset, the tracker has no position reference. During that time beats still flow, but they are marked as not locked.

Top module: `vidpos_tracker`

## Requirements
- R1: `m_tdata`, `m_tvalid`, `m_tlast` and `m_tuser` equal their `s_` counterparts in the same cycle, and `s_tready` equals `m_tready`.
- R2: After reset and before the first accepted beat with `s_tuser[0]`=1, `m_locked`=0, `m_col`=`m_row`=0 and all three error flags are 0.
- R3: A valid beat with `s_tuser[0]`=1 shows `m_locked`=1, `m_col`=0 and `m_row`=0. Once such a beat is accepted, `m_locked` stays 1 until reset.
- R4: An accepted, locked beat with `s_tlast`=0 makes the next beat's column one greater, on the same line.
- R5: An accepted, locked beat with `s_tlast`=1 makes the next beat's column 0 and its line one greater.
- R6: Position advances only on cycles where `s_tvalid` and `m_tready` are both 1. During a stall, the shown position holds.
- R7: `m_err_early`=1 on a valid, locked beat with `s_tlast`=1 whose column is below `cfg_width`-1.
- R8: `m_err_late`=1 on a valid, locked beat with `s_tlast`=0 whose column equals `cfg_width`-1. After that beat, the column keeps counting.
- R9: `m_err_short`=1 on a valid start-of-frame beat that arrives while locked and before `cfg_height` lines have been closed since the previous start-of-frame. The position then restarts at 0,0.
- R10: The column and line counters saturate at all ones and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | CW | Expected pixels per line (at least 1) |
| cfg_height | input | CW | Expected lines per frame |
| s_tdata | input | DATA_W | Upstream pixel |
| s_tvalid | input | 1 | Upstream valid |
| s_tready | output | 1 | Upstream ready (equals m_tready) |
| s_tlast | input | 1 | End of line |
| s_tuser | input | USER_W | Sideband; bit 0 marks start of frame |
| m_tdata | output | DATA_W | Downstream pixel |
| m_tvalid | output | 1 | Downstream valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | End of line, passed through |
| m_tuser | output | USER_W | Sideband, passed through |
| m_col | output | CW | Column of the current beat |
| m_row | output | CW | Line of the current beat |
| m_locked | output | 1 | Coordinates are valid |
| m_err_early | output | 1 | Line ended before the expected width |
| m_err_late | output | 1 | Line reached the last column without an end-of-line |
| m_err_short | output | 1 | Frame restarted before all lines were seen |

## Verification
Coordinates, lock and error flags are combinational on the beat that is presented, so they are due in the same cycle as the input. The position that an accepted beat sets up appears one clock edge later, on the next beat. The bench drives inputs one time unit after the rising edge and compares every output at the falling edge against a behavioural model. That model advances at the rising edge only when valid and ready were both high. A stalled cycle is therefore compared twice against the same expected position, and a start-of-frame held under stall is compared against 0,0 every time.

// File: rtl/vidpos_pkg.sv
package vidpos_pkg;

    // Tracker lock state: searching for the first start-of-frame, or locked.
    typedef enum logic {
        TRK_SEARCH = 1'b0,
        TRK_LOCKED = 1'b1
    } trk_state_e;

    // Framing violations detected on the current beat.
    typedef struct packed {
        logic early_eol;
        logic late_eol;
        logic short_frame;
    } frame_err_t;

    localparam frame_err_t FRAME_OK = '0;

endpackage

// File: rtl/vidpos_pos_ctr.sv
module vidpos_pos_ctr
    import vidpos_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_valid,
    input  logic          beat_fire,
    input  logic          beat_sof,
    input  logic          beat_eol,
    output logic [CW-1:0] cur_col,
    output logic [CW-1:0] cur_row,
    output logic [CW-1:0] lines_done,
    output logic          pos_locked,
    output logic          was_locked
);
    localparam logic [CW-1:0] CMAX = '1;

    trk_state_e    st_q;
    logic [CW-1:0] col_q;
    logic [CW-1:0] row_q;
    logic          restart;
    logic [CW-1:0] col_nx;
    logic [CW-1:0] row_nx;

    assign restart    = beat_valid && beat_sof;
    assign was_locked = (st_q == TRK_LOCKED);
    assign lines_done = row_q;

    // Position of the beat on the bus: a start-of-frame overrides stored state.
    always_comb begin
        pos_locked = was_locked || restart;
        if (restart) begin
            cur_col = '0;
            cur_row = '0;
        end else if (was_locked) begin
            cur_col = col_q;
            cur_row = row_q;
        end else begin
            cur_col = '0;
            cur_row = '0;
        end
    end

    // Position expected for the following beat (saturating).
    always_comb begin
        if (beat_eol) begin
            col_nx = '0;
            row_nx = (cur_row == CMAX) ? CMAX : cur_row + 1'b1;
        end else begin
            col_nx = (cur_col == CMAX) ? CMAX : cur_col + 1'b1;
            row_nx = cur_row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TRK_SEARCH;
            col_q <= '0;
            row_q <= '0;
        end else if (beat_fire && pos_locked) begin
            st_q  <= TRK_LOCKED;
            col_q <= col_nx;
            row_q <= row_nx;
        end
    end

endmodule

// File: rtl/vidpos_err_chk.sv
module vidpos_err_chk
    import vidpos_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          beat_valid,
    input  logic          beat_sof,
    input  logic          beat_eol,
    input  logic          pos_locked,
    input  logic          was_locked,
    input  logic [CW-1:0] cur_col,
    input  logic [CW-1:0] lines_done,
    input  logic [CW-1:0] cfg_width,
    input  logic [CW-1:0] cfg_height,
    output frame_err_t    err
);
    logic [CW-1:0] last_col;
    logic          judged;

    assign last_col = cfg_width - 1'b1;
    assign judged   = beat_valid && pos_locked;

    always_comb begin
        err             = FRAME_OK;
        err.early_eol   = judged && beat_eol && (cur_col < last_col);
        err.late_eol    = judged && !beat_eol && (cur_col == last_col);
        err.short_frame = beat_valid && beat_sof && was_locked
                          && (lines_done < cfg_height);
    end

endmodule

// File: rtl/vidpos_tracker.sv
module vidpos_tracker
    import vidpos_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int USER_W = 1,
    parameter int CW     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cfg_width,
    input  logic [CW-1:0]     cfg_height,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    input  logic [USER_W-1:0] s_tuser,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    output logic [USER_W-1:0] m_tuser,
    output logic [CW-1:0]     m_col,
    output logic [CW-1:0]     m_row,
    output logic              m_locked,
    output logic              m_err_early,
    output logic              m_err_late,
    output logic              m_err_short
);
    logic          fire;
    logic          sof;
    logic [CW-1:0] lines_done;
    logic          was_locked;
    frame_err_t    err;

    // Transparent pass-through of the stream (R1).
    assign m_tdata  = s_tdata;
    assign m_tvalid = s_tvalid;
    assign m_tlast  = s_tlast;
    assign m_tuser  = s_tuser;
    assign s_tready = m_tready;

    assign fire = s_tvalid && m_tready;
    assign sof  = s_tuser[0];

    vidpos_pos_ctr #(.CW(CW)) i_pos (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (s_tvalid),
        .beat_fire  (fire),
        .beat_sof   (sof),
        .beat_eol   (s_tlast),
        .cur_col    (m_col),
        .cur_row    (m_row),
        .lines_done (lines_done),
        .pos_locked (m_locked),
        .was_locked (was_locked)
    );

    vidpos_err_chk #(.CW(CW)) i_err (
        .beat_valid (s_tvalid),
        .beat_sof   (sof),
        .beat_eol   (s_tlast),
        .pos_locked (m_locked),
        .was_locked (was_locked),
        .cur_col    (m_col),
        .lines_done (lines_done),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .err        (err)
    );

    assign m_err_early = err.early_eol;
    assign m_err_late  = err.late_eol;
    assign m_err_short = err.short_frame;

endmodule

// File: rtl/vidpos_tracker_sva.sv
module vidpos_tracker_sva #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          s_tvalid,
    input logic          s_tlast,
    input logic          s_sof,
    input logic          m_tready,
    input logic [CW-1:0] m_col,
    input logic [CW-1:0] m_row,
    input logic          m_locked,
    input logic          m_err_early,
    input logic          m_err_late,
    input logic          m_err_short
);
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CMAX = '1;

    logic acc;
    assign acc = s_tvalid && m_tready;

    AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !m_locked |-> (m_col == '0 && m_row == '0 && !m_err_early && !m_err_late && !m_err_short)); // R2

    AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_sof) |-> (m_locked && m_col == '0 && m_row == '0)); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (acc && m_locked) |=> m_locked); // R3

    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc && m_locked && !s_tlast && m_col != CMAX)
        |=> (!(s_tvalid && !s_sof) || (m_col == $past(m_col) + ONE && m_row == $past(m_row)))); // R4

    AST_EOL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (acc && m_locked && s_tlast && m_row != CMAX)
        |=> (!(s_tvalid && !s_sof) || (m_col == '0 && m_row == $past(m_row) + ONE))); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && !m_tready && !s_sof && m_locked)
        |=> (!(s_tvalid && !s_sof) || (m_col == $past(m_col) && m_row == $past(m_row)))); // R6

    AST_EOL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(m_err_early && m_err_late)); // R7

    AST_LATE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        m_err_late |-> (s_tvalid && !s_tlast && m_locked)); // R8

    AST_SHORT_ON_SOF: assert property (@(posedge clk) disable iff (rst)
        m_err_short |-> (s_tvalid && s_sof)); // R9

    AST_COL_SAT: assert property (@(posedge clk) disable iff (rst)
        (acc && m_locked && !s_tlast && m_col == CMAX)
        |=> (!(s_tvalid && !s_sof) || m_col == CMAX)); // R10

endmodule

bind vidpos_tracker vidpos_tracker_sva #(.CW(CW)) i_vidpos_sva (
    .clk         (clk),
    .rst         (rst),
    .s_tvalid    (s_tvalid),
    .s_tlast     (s_tlast),
    .s_sof       (s_tuser[0]),
    .m_tready    (m_tready),
    .m_col       (m_col),
    .m_row       (m_row),
    .m_locked    (m_locked),
    .m_err_early (m_err_early),
    .m_err_late  (m_err_late),
    .m_err_short (m_err_short)
);

// File: tb/test_vidpos_tracker.sv
module test_vidpos_tracker;
    localparam int DW   = 16;
    localparam int CW   = 5;
    localparam int CMAX = 31;
    localparam int WID  = 4;
    localparam int HGT  = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] cfg_width;
    logic [CW-1:0] cfg_height;
    logic [DW-1:0] s_tdata;
    logic          s_tvalid;
    logic          s_tready;
    logic          s_tlast;
    logic [0:0]    s_tuser;
    logic [DW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready;
    logic          m_tlast;
    logic [0:0]    m_tuser;
    logic [CW-1:0] m_col;
    logic [CW-1:0] m_row;
    logic          m_locked;
    logic          m_err_early;
    logic          m_err_late;
    logic          m_err_short;

    always #2 clk = ~clk;

    vidpos_tracker #(.DATA_W(DW), .USER_W(1), .CW(CW)) i_vidpos_tracker (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .s_tuser(s_tuser),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .m_tuser(m_tuser),
        .m_col(m_col), .m_row(m_row), .m_locked(m_locked),
        .m_err_early(m_err_early), .m_err_late(m_err_late), .m_err_short(m_err_short)
    );

    int    checks = 0;
    int    fails  = 0;
    int    ref_col = 0;
    int    ref_row = 0;
    bit    ref_lock = 0;
    int    dseq = 0;
    string ctx = "R2";
    bit    done = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive, compare at falling edge, advance model at rising edge.
    task automatic cyc(bit v, bit r, bit l, bit s);
        int ec, er;
        bit el, ee, elt, es;
        dseq++;
        s_tvalid = v; m_tready = r; s_tlast = l; s_tuser = s;
        s_tdata  = DW'(dseq * 37 + 5);
        @(negedge clk);
        el = ref_lock || (v && s);
        if (v && s) begin ec = 0; er = 0; end
        else if (ref_lock) begin ec = ref_col; er = ref_row; end
        else begin ec = 0; er = 0; end
        ee  = v && el && l && (ec < WID - 1);
        elt = v && el && !l && (ec == WID - 1);
        es  = v && s && ref_lock && (ref_row < HGT);
        // R1 pass-through
        chk("R1", "passthru", {m_tdata, m_tvalid, m_tlast, m_tuser, s_tready},
            {DW'(dseq * 37 + 5), v, l, s, r});
        chk(ctx, "locked", m_locked, el);
        chk(ctx, "col", m_col, ec);
        chk(ctx, "row", m_row, er);
        chk(ctx, "err_early", m_err_early, ee);
        chk(ctx, "err_late", m_err_late, elt);
        chk(ctx, "err_short", m_err_short, es);
        @(posedge clk);
        if (v && r && el) begin
            ref_lock = 1;
            if (l) begin
                ref_col = 0;
                ref_row = (er == CMAX) ? CMAX : er + 1;
            end else begin
                ref_col = (ec == CMAX) ? CMAX : ec + 1;
                ref_row = er;
            end
        end
        #1;
    endtask

    task automatic send_line(int n, bit sof, int stall);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < stall; k++) cyc(1, 0, i == n - 1, sof && i == 0);
            cyc(1, 1, i == n - 1, sof && i == 0);
        end
    endtask

    task automatic send_frame(int stall);
        for (int ln = 0; ln < HGT; ln++) send_line(WID, ln == 0, stall);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cfg_width = CW'(WID); cfg_height = CW'(HGT);
        s_tvalid = 0; m_tready = 1; s_tlast = 0; s_tuser = 0; s_tdata = '0;
        rst = 1;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R2", "reset locked", m_locked, 0);
        chk("R2", "reset col", m_col, 0);
        chk("R2", "reset row", m_row, 0);
        @(posedge clk); #1;
        rst = 0;

        // R2: beats before any start-of-frame are passed but unlocked
        ctx = "R2";
        cyc(1, 1, 0, 0); cyc(1, 1, 1, 0); cyc(0, 1, 0, 0); cyc(1, 0, 0, 0); cyc(1, 1, 0, 0);

        // R3 R4 R5: well-formed frames
        ctx = "R3"; send_frame(0);
        ctx = "R4"; send_frame(0);
        ctx = "R5"; send_frame(0);

        // R6: stalls before every beat plus idle cycles
        ctx = "R6";
        send_line(WID, 1, 2);
        cyc(0, 1, 0, 0); cyc(0, 0, 0, 0);
        send_line(WID, 0, 1);
        send_line(WID, 0, 3);

        // R7: short line inside a frame
        ctx = "R7";
        send_line(WID, 1, 0); send_line(2, 0, 0); send_line(1, 0, 0);

        // R8: overlong line keeps counting
        ctx = "R8";
        send_line(WID, 1, 0); send_line(WID + 3, 0, 0); send_line(WID, 0, 0);

        // R9: frame restart after one line, then after a full frame
        ctx = "R9";
        send_line(WID, 1, 0); send_line(WID, 1, 0);
        send_line(WID, 0, 0); send_line(WID, 0, 0);
        send_line(2, 1, 1);
        send_frame(0);

        // R10: column and line saturation
        ctx = "R10";
        send_line(CMAX + 8, 1, 0);
        for (int i = 0; i < CMAX + 4; i++) cyc(1, 1, 1, 0);

        // Mixed traffic
        ctx = "R6";
        for (int i = 0; i < 600; i++)
            cyc(($urandom % 4) != 0, ($urandom % 3) != 0,
                ($urandom % 5) == 0, ($urandom % 40) == 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule